// File: doc/BRIEF.md
# Memory Bus Handshake Master

This block sits between a processor core and a clocked request/ready memory bus. The core uses it for instruction fetches, loads and stores. The core offers one word request at a time. A request carries a direction flag, a 16-bit byte address and, for stores, a write word. The master registers the request and raises the read or write strobe with the word address and write data. It keeps them steady for as many cycles as the memory needs. When the memory's ready line is sampled high on a rising edge, the master latches the read word. It then reports completion to the core with a one-cycle done pulse.

Every transfer is a four-phase exchange. After ready is seen, the master takes both strobes low for one full cycle. The memory samples that idle bus on the next rising edge, and only after that edge does the master accept a new request. Byte address bit 0 is not driven: words are two bytes, so the bus carries bits 15 down to 1 only. Reads and stores use the two directions of a single 16-bit data bus, shown here as a separate input and output.

Top module: `mbus_master`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `mem_read`, `mem_write` and `done` are low, `req_ready` is high and `rdata` is 0.
- R2: `req_ready` is high only while no transfer is in progress. A request with `req_valid` high on a rising edge while `req_ready` is high is accepted, and a strobe is high in the next cycle.
- R3: `mem_addr` equals bits 15..1 of the accepted `req_addr`, and it stays at that value for the whole time a strobe is high, even when the core's request inputs change.
- R4: For an accepted request with `req_write` = 0, `mem_read` is high and `mem_write` is low.
- R5: For an accepted request with `req_write` = 1, `mem_write` is high, `mem_read` is low, and `mem_wdata` holds the accepted `req_wdata` for the whole strobe period.
- R6: `mem_read` and `mem_write` are never high in the same cycle.
- R7: While a strobe is high and `mem_ready` is sampled low, the strobe, address and write data stay unchanged, with no cycle limit.
- R8: Suppose a strobe is high and `mem_ready` is sampled high on a rising edge. In the next cycle both strobes are low and `done` is high, and `done` lasts exactly one cycle. If the memory answers L cycles after acceptance, `done` is high L+1 cycles after the accepting edge.
- R9: On a read, `rdata` takes the value of `mem_rdata` at the edge where `mem_ready` is first seen. `rdata` changes in no other cycle and keeps its value through later writes and idle cycles.
- R10: In the cycle where `done` is high, `req_ready` is low and any `req_valid` is not accepted. `req_ready` returns in the next cycle. A `mem_ready` seen while no strobe is high has no effect on the strobes, `done` or `rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core offers a request this cycle |
| req_write | input | 1 | 1 = store, 0 = read/fetch |
| req_addr | input | 16 | Byte address of the request |
| req_wdata | input | 16 | Word to store |
| req_ready | output | 1 | Master is idle and accepts a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last word read, held |
| mem_read | output | 1 | Read strobe to memory |
| mem_write | output | 1 | Write strobe to memory |
| mem_addr | output | 15 | Word address (byte address bits 15..1) |
| mem_wdata | output | 16 | Write side of the data bus |
| mem_rdata | input | 16 | Read side of the data bus |
| mem_ready | input | 1 | Memory has completed the strobed access |

## Verification
A strobe appears one cycle after the accepting edge. `done` and the new `rdata` appear L+1 cycles after it when the memory answers after L cycles, and `req_ready` returns one cycle after `done`. The driver stamps each queued item with that due cycle from a free-running edge counter. The monitor samples on falling edges, which lies between the registered output change and the next sampling edge, and compares the cycle in which `done` is seen with the stamp. A stray ready while idle and a request raised during the release cycle are each followed by a check of the strobes and `done` in the following cycles.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RELEASE = 2'd2
    } mbus_state_t;

    typedef enum logic {
        KIND_RD = 1'b0,
        KIND_WR = 1'b1
    } mbus_kind_t;

    function automatic logic strobe_for(input mbus_state_t st,
                                        input mbus_kind_t kd,
                                        input mbus_kind_t want);
        return (st == ST_ACCESS) && (kd == want);
    endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        mem_ready,
    output logic        load,
    output logic        capture,
    output mbus_state_t state
);
    mbus_state_t nxt;

    always_comb begin
        nxt     = state;
        load    = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    load = 1'b1;
                    nxt  = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (mem_ready) begin
                    capture = 1'b1;
                    nxt     = ST_RELEASE;
                end
            end
            ST_RELEASE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/mbus_req_reg.sv
module mbus_req_reg
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output mbus_kind_t        kind,
    output logic [ADDR_W-2:0] word_addr,
    output logic [DATA_W-1:0] wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            kind      <= KIND_RD;
            word_addr <= '0;
            wdata     <= '0;
        end else if (load) begin
            kind      <= in_write ? KIND_WR : KIND_RD;
            word_addr <= in_addr[ADDR_W-1:1];
            wdata     <= in_wdata;
        end
    end
endmodule

// File: rtl/mbus_rd_hold.sv
module mbus_rd_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (take) held <= bus_in;
    end
endmodule

// File: rtl/mbus_master.sv
module mbus_master
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_read,
    output logic              mem_write,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    mbus_state_t state;
    mbus_kind_t  kind;
    logic        load;
    logic        capture;

    mbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .mem_ready (mem_ready),
        .load      (load),
        .capture   (capture),
        .state     (state)
    );

    mbus_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .in_write  (req_write),
        .in_addr   (req_addr),
        .in_wdata  (req_wdata),
        .kind      (kind),
        .word_addr (mem_addr),
        .wdata     (mem_wdata)
    );

    mbus_rd_hold #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .take   (capture && (kind == KIND_RD)),
        .bus_in (mem_rdata),
        .held   (rdata)
    );

    assign mem_read  = strobe_for(state, kind, KIND_RD);
    assign mem_write = strobe_for(state, kind, KIND_WR);
    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_RELEASE);
endmodule

// File: rtl/mbus_master_chk.sv
module mbus_master_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic [DATA_W-1:0] rdata,
    input logic              mem_read,
    input logic              mem_write,
    input logic [ADDR_W-2:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready
);
    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |=> (mem_read || mem_write));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_read && !mem_write));

    p_rd_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_read && !mem_ready) |=> (mem_read && $stable(mem_addr)));

    p_wr_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_write && !mem_ready) |=> (mem_write && $stable(mem_addr) && $stable(mem_wdata)));

    p_drop_r8: assert property (@(posedge clk) disable iff (rst)
        ((mem_read || mem_write) && mem_ready) |=> (!mem_read && !mem_write && done));

    p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!req_ready && !mem_read && !mem_write));

    p_release_end_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);

    p_stray_r10: assert property (@(posedge clk) disable iff (rst)
        (!mem_read && !mem_write && !done && mem_ready) |=> !done);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> done);
endmodule

bind mbus_master mbus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .rdata     (rdata),
    .mem_read  (mem_read),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/sim_mbus_master.sv
`timescale 1ns/1ps
module sim_mbus_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done, mem_read, mem_write;
    logic [15:0] rdata, mem_wdata;
    logic [14:0] mem_addr;
    logic [15:0] mem_rdata = 16'hDEAD;
    logic        mem_ready = 1'b0;

    always #10 clk = ~clk;

    mbus_master u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .mem_read(mem_read), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] exp_rdata;
        int          exp_cyc;
    } item_t;

    item_t       sb[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          cyc     = 0;
    int          lat_cfg = 1;
    int          wait_cnt = 0;
    bit          force_rdy = 1'b0;
    logic [15:0] mem_arr [0:255];
    logic [15:0] shadow  [0:255];
    logic [15:0] last_rd = 16'h0000;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // memory model: answers lat_cfg falling edges after a strobe appears
    always @(negedge clk) begin
        if (mem_read || mem_write) begin
            wait_cnt = wait_cnt + 1;
            if (wait_cnt >= lat_cfg && !mem_ready) begin
                mem_ready = 1'b1;
                if (mem_write) mem_arr[mem_addr[7:0]] = mem_wdata;
                else           mem_rdata = mem_arr[mem_addr[7:0]];
            end
        end else begin
            wait_cnt  = 0;
            mem_ready = force_rdy;
            mem_rdata = 16'hDEAD;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_read || mem_write) begin
                chk(!(mem_read && mem_write), "R6", {mem_read, mem_write}, 2'b00);
                if (sb.size() > 0) begin
                    chk(mem_addr == sb[0].addr[15:1], "R3", mem_addr, sb[0].addr[15:1]);
                    if (sb[0].wr) begin
                        chk(mem_write && !mem_read, "R5", {mem_read, mem_write}, 2'b01);
                        chk(mem_wdata == sb[0].wdata, "R5", mem_wdata, sb[0].wdata);
                    end else begin
                        chk(mem_read && !mem_write, "R4", {mem_read, mem_write}, 2'b10);
                    end
                end
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(cyc == it.exp_cyc, "R8", cyc, it.exp_cyc);
                    chk(!mem_read && !mem_write, "R8", {mem_read, mem_write}, 2'b00);
                    chk(rdata == it.exp_rdata, "R9", rdata, it.exp_rdata);
                end
            end
        end
    end

    task automatic xfer(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input int lat, input bit poke);
        item_t it;
        @(negedge clk);
        lat_cfg = lat;
        chk(req_ready === 1'b1, "R2", req_ready, 1);
        it.wr = wr; it.addr = a; it.wdata = d;
        it.exp_cyc = cyc + lat + 1;
        if (wr) begin
            shadow[a[8:1]] = d;
            it.exp_rdata = last_rd;
        end else begin
            it.exp_rdata = shadow[a[8:1]];
            last_rd = it.exp_rdata;
        end
        sb.push_back(it);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 16'h0; req_wdata = 16'h0; req_write = ~wr;
        chk(mem_read || mem_write, "R2", {mem_read, mem_write}, wr ? 2'b01 : 2'b10);
        chk(req_ready == 1'b0, "R2", req_ready, 0);
        while (!done) @(negedge clk);
        chk(req_ready == 1'b0, "R10", req_ready, 0);
        if (poke) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0100;
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", req_ready, 1);
        chk(!mem_read && !mem_write, "R10", {mem_read, mem_write}, 2'b00);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            chk(!mem_read && !mem_write && !done, "R10", {mem_read, mem_write, done}, 3'b000);
        end
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = (16'(i) * 16'h0101) ^ 16'h5A00;
            shadow[i]  = (16'(i) * 16'h0101) ^ 16'h5A00;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mem_read && !mem_write && !done, "R1", {mem_read, mem_write, done}, 3'b000);
        chk(req_ready == 1'b1 && rdata == 16'h0, "R1", {req_ready, rdata}, {1'b1, 16'h0});
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && !mem_read && !mem_write && rdata == 16'h0, "R1",
            {req_ready, mem_read, mem_write, rdata}, {1'b1, 2'b00, 16'h0});

        xfer(1'b0, 16'h0010, 16'h0, 1, 1'b0);       // R4 fastest read
        xfer(1'b1, 16'h0020, 16'hBEEF, 3, 1'b0);    // R5 write
        xfer(1'b0, 16'h0020, 16'h0, 2, 1'b0);       // readback of R5 write
        xfer(1'b0, 16'h0031, 16'h0, 1, 1'b0);       // R3 byte bit 0 dropped
        xfer(1'b0, 16'h0042, 16'h0, 25, 1'b0);      // R7 long wait
        xfer(1'b1, 16'h0020, 16'h1234, 4, 1'b0);    // R9 write leaves rdata
        chk(rdata == last_rd, "R9", rdata, last_rd);

        // R10: stray ready while idle
        @(negedge clk);
        force_rdy = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk(!mem_read && !mem_write && !done, "R10", {mem_read, mem_write, done}, 3'b000);
            chk(rdata == last_rd, "R10", rdata, last_rd);
        end
        force_rdy = 1'b0;

        xfer(1'b0, 16'h0020, 16'h0, 1, 1'b1);       // R10 request during release
        xfer(1'b1, 16'h01FE, 16'hA5C3, 1, 1'b0);
        xfer(1'b0, 16'h01FE, 16'h0, 6, 1'b0);
        xfer(1'b0, 16'h0000, 16'h0, 2, 1'b0);

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R8", sb.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule